// File: doc/BRIEF.md
# Daisy-Chain Converter Readback Host

This block is the host-side master for a chain of serial 16-bit analog-to-digital converters wired output-to-input. A start request raises the convert strobe while the serial clock is held low, which puts every converter into chained mode without a busy flag. The block then waits a programmed number of system clocks for the conversion to finish. After that it issues exactly 16×N serial clock pulses and samples the serial data line on each high-to-low transition of the serial clock.

The received bits are gathered into N words. Once the last bit has been taken, the convert strobe drops and the words are offered on a valid/ready stream. The first word offered is the first word received, which comes from the converter closest to the host. A flag marks the final word. The number of converters is an elaboration parameter. The clock divider and the conversion wait are sampled from input ports at the moment a start is accepted. A new start is only taken once the previous readback has finished and every word has been handed over.

Top module: `chain_rdout_host`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `cnv_o`, `sck_o` and `word_valid_o` are all low.
- R2: A start seen in the idle state drives `cnv_o` high on the next cycle, with `sck_o` low. `sck_o` then stays low for max(W,1) cycles, where W is `conv_wait_i` as sampled at that start.
- R3: After the wait, `sck_o` makes exactly 16×N pulses. Each pulse is high for H cycles and low for H cycles, where H = max(`half_div_i`,1) as sampled at start, so the divide ratio is 2H.
- R4: `sdo_i` is sampled in the cycle in which `sck_o` goes from high to low. Bits arrive MSB first. Bits 1 to 16 form word 0, bits 17 to 32 form word 1, and so on.
- R5: `cnv_o` stays high from the cycle after start until the last falling edge of `sck_o`. It goes low on that same edge, together with `word_valid_o` going high, and `sck_o` is never high while `cnv_o` is low.
- R6: Words are offered in the order they were received. While `word_valid_o` is high and `word_ready_i` is low, `word_data_o` and `word_last_o` hold their values.
- R7: `word_last_o` is high only with the N-th word. After that word is accepted, `word_valid_o` drops.
- R8: A start that arrives while a transfer is in progress, or while words are still waiting, is ignored. It causes no extra conversion and no change to the serial clock.
- R9: Changes to `half_div_i` or `conv_wait_i` after a start has been accepted have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a conversion and readback |
| half_div_i | input | DIV_W | Serial clock half period in system clocks (0 treated as 1) |
| conv_wait_i | input | WAIT_W | Conversion wait in system clocks (0 treated as 1) |
| cnv_o | output | 1 | Convert strobe to the chain |
| sck_o | output | 1 | Serial clock to the chain |
| sdo_i | input | 1 | Serial data from the converter nearest the host |
| word_valid_o | output | 1 | A received word is offered |
| word_data_o | output | WORD_W | Offered word |
| word_last_o | output | 1 | Offered word is the final one of the transfer |
| word_ready_i | input | 1 | Consumer takes the offered word |

## Verification
The chain is driven with word sets chosen to expose specific errors. A single set MSB in the first word together with a single set LSB in the second word separates MSB-first order from LSB-first order, and also shows whether words are swapped. Alternating-bit words and all-ones/all-zero neighbours show a sampling point that is off by one serial edge. Walking-one words catch word boundaries that slip by a bit.

The runs use several divider and wait settings, including the zero values that are clamped to one. They also use three consumer behaviours: always ready, pseudo-random ready, and a long stall. The stall tests that the offered word holds, and the varying settings test that the pulse timing follows the values sampled at start. In one run start is held high through the whole transfer, to show that it is ignored while busy. In another the configuration inputs are changed mid-transfer, to show that they are latched at start.

// File: rtl/chain_host_pkg.sv
package chain_host_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CONV  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_EMIT  = 2'd3
   } seq_state_t;

   localparam int MAX_DEVICES = 8;

endpackage

// File: rtl/chain_sck_gen.sv
module chain_sck_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] half_i,
   output logic             sck_o,
   output logic             fall_o
);

   logic [DIV_W-1:0] hcnt;
   logic             sck_q;
   logic             at_end;

   assign at_end = (hcnt == half_i - DIV_W'(1));
   assign sck_o  = sck_q;
   assign fall_o = run_i && at_end && sck_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt  <= '0;
         sck_q <= 1'b0;
      end else if (!run_i) begin
         hcnt  <= '0;
         sck_q <= 1'b0;
      end else if (at_end) begin
         hcnt  <= '0;
         sck_q <= ~sck_q;
      end else begin
         hcnt  <= hcnt + DIV_W'(1);
      end
   end

   // half period counter never passes its terminal value
   assert_hcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (hcnt < half_i));

endmodule

// File: rtl/chain_seq.sv
module chain_seq
   import chain_host_pkg::*;
#(
   parameter int NUM_DEV = 4,
   parameter int WORD_W  = 16,
   parameter int DIV_W   = 8,
   parameter int WAIT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DIV_W-1:0]  half_i,
   input  logic [WAIT_W-1:0] wait_i,
   input  logic              fall_i,
   input  logic              pop_i,
   output logic              cnv_o,
   output logic              run_o,
   output logic [DIV_W-1:0]  half_q_o,
   output logic              shift_o,
   output logic              emit_o,
   output logic              last_o
);

   localparam int TOT = NUM_DEV * WORD_W;
   localparam int BCW = $clog2(TOT + 1);
   localparam int IW  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

   seq_state_t        state;
   logic [WAIT_W-1:0] wcnt;
   logic [DIV_W-1:0]  half_q;
   logic [BCW-1:0]    bcnt;
   logic [IW-1:0]     widx;
   logic              cnv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         wcnt   <= '0;
         half_q <= DIV_W'(1);
         bcnt   <= '0;
         widx   <= '0;
         cnv_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  state  <= ST_CONV;
                  cnv_q  <= 1'b1;
                  wcnt   <= wait_i;
                  half_q <= (half_i == '0) ? DIV_W'(1) : half_i;
                  bcnt   <= '0;
                  widx   <= '0;
               end
            end
            ST_CONV: begin
               if (wcnt <= WAIT_W'(1)) state <= ST_SHIFT;
               else                    wcnt  <= wcnt - WAIT_W'(1);
            end
            ST_SHIFT: begin
               if (fall_i) begin
                  bcnt <= bcnt + BCW'(1);
                  if (bcnt == BCW'(TOT - 1)) begin
                     state <= ST_EMIT;
                     cnv_q <= 1'b0;
                  end
               end
            end
            ST_EMIT: begin
               if (pop_i) begin
                  if (widx == IW'(NUM_DEV - 1)) state <= ST_IDLE;
                  else                         widx  <= widx + IW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cnv_o    = cnv_q;
   assign run_o    = (state == ST_SHIFT);
   assign half_q_o = half_q;
   assign shift_o  = fall_i && (state == ST_SHIFT);
   assign emit_o   = (state == ST_EMIT);
   assign last_o   = (state == ST_EMIT) && (widx == IW'(NUM_DEV - 1));

   // bit counter cannot exceed the transfer length
   assert_bit_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt <= BCW'(TOT));

   // busy states never re-enter conversion
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT || state == ST_EMIT) |=> (state != ST_CONV));

   // latched divider stays fixed while shifting
   assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |=> $stable(half_q));

endmodule

// File: rtl/chain_rx_buffer.sv
module chain_rx_buffer #(
   parameter int NUM_DEV = 4,
   parameter int WORD_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   input  logic              pop_i,
   output logic [WORD_W-1:0] word_o
);

   localparam int TOT = NUM_DEV * WORD_W;

   logic [TOT-1:0] sreg;

   generate
      if (NUM_DEV == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)       sreg <= '0;
            else if (shift_i) sreg <= {sreg[TOT-2:0], bit_i};
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n)       sreg <= '0;
            else if (shift_i) sreg <= {sreg[TOT-2:0], bit_i};
            else if (pop_i)   sreg <= {sreg[TOT-WORD_W-1:0], {WORD_W{1'b0}}};
         end
      end
   endgenerate

   assign word_o = sreg[TOT-1 -: WORD_W];

   // shifting and popping belong to disjoint phases
   assert_phase_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_i && pop_i));

endmodule

// File: rtl/chain_rdout_host.sv
module chain_rdout_host #(
   parameter int NUM_DEV = 4,
   parameter int WORD_W  = 16,
   parameter int DIV_W   = 8,
   parameter int WAIT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DIV_W-1:0]  half_div_i,
   input  logic [WAIT_W-1:0] conv_wait_i,
   output logic              cnv_o,
   output logic              sck_o,
   input  logic              sdo_i,
   output logic              word_valid_o,
   output logic [WORD_W-1:0] word_data_o,
   output logic              word_last_o,
   input  logic              word_ready_i
);

   generate
      if (NUM_DEV < 1 || NUM_DEV > chain_host_pkg::MAX_DEVICES) begin : g_bad_dev
         $error("chain_rdout_host: NUM_DEV out of range");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("chain_rdout_host: WORD_W too small");
      end
      if (DIV_W < 1 || WAIT_W < 1) begin : g_bad_cnt
         $error("chain_rdout_host: counter width too small");
      end
   endgenerate

   logic             run;
   logic             fall;
   logic             shift;
   logic             pop;
   logic [DIV_W-1:0] half_q;

   assign pop = word_valid_o && word_ready_i;

   chain_seq #(
      .NUM_DEV (NUM_DEV),
      .WORD_W  (WORD_W),
      .DIV_W   (DIV_W),
      .WAIT_W  (WAIT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .half_i   (half_div_i),
      .wait_i   (conv_wait_i),
      .fall_i   (fall),
      .pop_i    (pop),
      .cnv_o    (cnv_o),
      .run_o    (run),
      .half_q_o (half_q),
      .shift_o  (shift),
      .emit_o   (word_valid_o),
      .last_o   (word_last_o)
   );

   chain_sck_gen #(
      .DIV_W (DIV_W)
   ) u_sck (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .half_i (half_q),
      .sck_o  (sck_o),
      .fall_o (fall)
   );

   chain_rx_buffer #(
      .NUM_DEV (NUM_DEV),
      .WORD_W  (WORD_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift),
      .bit_i   (sdo_i),
      .pop_i   (pop),
      .word_o  (word_data_o)
   );

   // chained mode needs the serial clock low as the strobe rises
   assert_cnv_rise_sck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_o) |-> !sck_o);

   // serial clock only toggles inside the strobe window
   assert_sck_in_cnv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sck_o |-> cnv_o);

   // strobe drops exactly as the first word is offered
   assert_cnv_fall_emit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnv_o) |-> word_valid_o);

   // stalled word holds
   assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && !word_ready_i) |=>
         (word_valid_o && $stable(word_data_o) && $stable(word_last_o)));

   // stream ends after the final word
   assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && word_ready_i && word_last_o) |=> !word_valid_o);

endmodule

// File: tb/chain_rdout_host_bench.sv
module chain_rdout_host_bench;

   localparam int ND  = 4;
   localparam int WW  = 16;
   localparam int DW  = 8;
   localparam int TW  = 12;
   localparam int TOT = ND * WW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [DW-1:0] half_div_i = '0;
   logic [TW-1:0] conv_wait_i = '0;
   logic          cnv_o, sck_o, sdo_i;
   logic          word_valid_o, word_last_o;
   logic [WW-1:0] word_data_o;
   logic          word_ready_i = 1'b1;

   always #2 clk = ~clk;

   chain_rdout_host #(.NUM_DEV(ND), .WORD_W(WW), .DIV_W(DW), .WAIT_W(TW)) u_chain_rdout_host (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_div_i(half_div_i),
      .conv_wait_i(conv_wait_i), .cnv_o(cnv_o), .sck_o(sck_o), .sdo_i(sdo_i),
      .word_valid_o(word_valid_o), .word_data_o(word_data_o),
      .word_last_o(word_last_o), .word_ready_i(word_ready_i));

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // converter chain model: one long shift register, nearest device first
   logic [WW-1:0]  vals [ND];
   logic [TOT-1:0] chain = '0;
   assign sdo_i = chain[TOT-1];

   always @(posedge cnv_o) begin
      for (int i = 0; i < ND; i++) chain[TOT-1-i*WW -: WW] = vals[i];
   end
   always @(negedge sck_o) begin
      #1 chain = chain << 1;
   end

   // behavioural reference model
   int            m_busy = 0;
   int            m_c = 0;
   int            m_wm = 1;
   int            m_h = 1;
   int            m_end = 0;
   logic [WW-1:0] q [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0;
         q.delete();
      end else if (m_busy == 0) begin
         if (start_i) begin
            m_busy = 1;
            m_c    = 0;
            m_wm   = (conv_wait_i == 0) ? 1 : int'(conv_wait_i);
            m_h    = (half_div_i == 0) ? 1 : int'(half_div_i);
            m_end  = m_wm + 2 * m_h * TOT;
            q.delete();
            for (int i = 0; i < ND; i++) q.push_back(vals[i]);
         end
      end else begin
         if (m_c >= m_end && word_ready_i) begin
            void'(q.pop_front());
            if (q.size() == 0) m_busy = 0;
         end
         m_c++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic e_cnv, e_sck, e_val, e_last;
         int   m;
         e_cnv  = (m_busy != 0) && (m_c < m_end);
         m      = m_c - m_wm;
         e_sck  = (m_busy != 0) && (m >= 0) && (m_c < m_end) && (((m / m_h) % 2) == 1);
         e_val  = (m_busy != 0) && (m_c >= m_end);
         e_last = e_val && (q.size() == 1);
         chk("R2 R5 R8 cnv", 32'(cnv_o), 32'(e_cnv));
         chk("R3 R9 sck", 32'(sck_o), 32'(e_sck));
         chk("R5 R6 valid", 32'(word_valid_o), 32'(e_val));
         chk("R7 last", 32'(word_last_o), 32'(e_last));
         if (e_val && q.size() > 0) chk("R4 R6 data", 32'(word_data_o), 32'(q[0]));
      end
   end

   // consumer behaviour: 0 always ready, 1 pseudo-random, 2 stall then ready
   int          rdy_mode = 0;
   int          stall = 0;
   logic [15:0] lfsr = 16'hACE1;
   initial begin
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (rdy_mode)
            0: word_ready_i = 1'b1;
            1: word_ready_i = lfsr[0];
            default: begin
               word_ready_i = (stall >= 20);
               if (word_valid_o) stall++;
            end
         endcase
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (m_busy != 0) @(negedge clk);
   endtask

   task automatic run(input logic [WW-1:0] a, input logic [WW-1:0] b,
                      input logic [WW-1:0] c, input logic [WW-1:0] d,
                      input int w, input int h, input int rm, input bit hold_start,
                      input bit poke_cfg);
      vals[0] = a; vals[1] = b; vals[2] = c; vals[3] = d;
      rdy_mode = rm; stall = 0;
      @(negedge clk);
      conv_wait_i = TW'(w);
      half_div_i  = DW'(h);
      start_i     = 1'b1;
      @(negedge clk);
      if (!hold_start) start_i = 1'b0;
      if (poke_cfg) begin
         repeat (3) @(negedge clk);
         half_div_i  = DW'(7);
         conv_wait_i = TW'(40);
      end
      wait_idle();
      start_i = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 cnv in reset", 32'(cnv_o), 32'd0);
      chk("R1 sck in reset", 32'(sck_o), 32'd0);
      chk("R1 valid in reset", 32'(word_valid_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", 32'(word_valid_o), 32'd0);
      // bit order and word order
      run(16'h8000, 16'h0001, 16'hFFFF, 16'h0000, 0, 1, 0, 1'b0, 1'b0);
      // off-by-one edge, start held high through busy (R8)
      run(16'hAAAA, 16'h5555, 16'h1234, 16'hFEDC, 5, 2, 1, 1'b1, 1'b0);
      // word boundary, long stall, config changed mid-run (R9)
      run(16'h0001, 16'h0002, 16'h4000, 16'h8001, 1, 3, 2, 1'b0, 1'b1);
      // zero divider and small wait clamp
      run(16'h0F0F, 16'hF0F0, 16'h7FFE, 16'hC003, 2, 0, 1, 1'b0, 1'b0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule